// File: doc/BRIEF.md
# Switch-Gated Lamp Pattern Sequencer

This block steps five lamp outputs through a fixed, repeating four-step cumulative pattern while a level-sensitive enable switch is on. The pattern is: all dark, then the first two lamps lit, then the first four lit, then all five lit, then back to all dark. Each step lasts one "second". A prescaler produces that second by dividing the system clock by the parameter `CLKS_PER_STEP`. Simulation can set this parameter to a small value.

Inside is a two-bit step counter. Each bit is held in its own flip-flop, and the counter moves through 00, 01, 10, 11 and wraps back to 00. It advances only on a prescaler tick, and only while the switch is on. The lamp vector is decoded from the step alone and registered, so it changes on the same clock edge as the step.

Turning the switch off parks the machine: the step goes to 00, all lamps go dark and the prescaler clears. After the switch comes back on, the dark step lasts a full second before the first advance. The step code is also brought out for observation.

Top module: `lamp_sequencer`

## Requirements
- R1: While `rst_ni` is low (asynchronous, active low), `lamp_o` is 00000 and `state_o` is 00.
- R2: With the switch on, `state_o` only ever moves 00→01→10→11→00. Each move adds one modulo 4, and no code is skipped.
- R3: With the switch held on, every step holds for exactly `CLKS_PER_STEP` rising clock edges. The value is unchanged after `CLKS_PER_STEP`-1 edges and has moved after the next edge.
- R4: The lamp vector is decoded as follows, with bit 0 of `lamp_o` being lamp 1: step 00 → 5'b00000, step 01 → 5'b00011, step 10 → 5'b01111, step 11 → 5'b11111.
- R5: `lamp_o` always equals the R4 decode of `state_o`, since both change on the same edge.
- R6: At the first rising edge with `switch_i` low, `state_o` becomes 00 and `lamp_o` becomes 00000. Both stay there while the switch remains off.
- R7: After the switch turns on, the first advance from 00 comes after exactly `CLKS_PER_STEP` edges, because the prescaler restarted from zero.
- R8: The state changes by at most one step per clock. With the switch on, the state never changes on an edge that does not end a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| switch_i | input | 1 | Enable switch level, 1 = run |
| lamp_o | output | 5 | Lamp drive, bit 0 = lamp 1 |
| state_o | output | 2 | Current step code |

## Verification
The bench checks each step at its last cycle and again one edge later. This catches a prescaler that is off by one, which would advance one edge early or late. It runs more than two full rounds, so a wrap from 11 that lands anywhere other than 00 shows up as a wrong step code and wrong lamps. The switch is dropped mid-sequence to catch a design that freezes instead of clearing to dark. On re-enable, a prescaler that kept its old count would cut the first dark step short. A decoder with the lamp order reversed, or with a bad count on step 11, produces a lamp vector that mismatches the bench's model.

// File: rtl/lamp_seq_pkg.sv
package lamp_seq_pkg;
  localparam int unsigned NUM_LAMPS = 5;
  localparam int unsigned STATE_W   = 2;
  typedef logic [STATE_W-1:0]   step_t;
  typedef logic [NUM_LAMPS-1:0] lamps_t;

  // two more lamps per step, saturating at all lamps
  function automatic lamps_t lamp_mask(input step_t s);
    int unsigned lit;
    lamps_t m;
    lit = 32'(s) * 2;
    if (lit > NUM_LAMPS) lit = NUM_LAMPS;
    for (int unsigned i = 0; i < NUM_LAMPS; i++) m[i] = (i < lit);
    return m;
  endfunction
endpackage

// File: rtl/step_prescaler.sv
module step_prescaler #(
  parameter int unsigned CLKS_PER_STEP = 50_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CNT_W = (CLKS_PER_STEP > 1) ? $clog2(CLKS_PER_STEP) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CLKS_PER_STEP - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_q) < CLKS_PER_STEP);
  assert_idle_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/step_fsm.sv
module step_fsm
  import lamp_seq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  run_i,
  input  logic  tick_i,
  output step_t state_d_o,
  output step_t state_q_o
);
  step_t state_q;
  step_t state_d;

  always_comb begin
    if (!run_i)      state_d = '0;
    else if (tick_i) state_d = state_q + 1'b1;
    else             state_d = state_q;
  end

  // each state bit in its own flop
  for (genvar b = 0; b < STATE_W; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q[b] <= 1'b0;
      else         state_q[b] <= state_d[b];
    end
  end

  assign state_d_o = state_d;
  assign state_q_o = state_q;

  assert_step_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i) |=> (state_q == $past(state_q) + 1'b1));
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i) |=> $stable(state_q));
  assert_off_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (state_q == '0));
endmodule

// File: rtl/lamp_register.sv
module lamp_register
  import lamp_seq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  step_t  state_d_i,
  output lamps_t lamp_o
);
  lamps_t lamp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lamp_q <= '0;
    else         lamp_q <= lamp_mask(state_d_i);
  end

  assign lamp_o = lamp_q;
endmodule

// File: rtl/lamp_sequencer.sv
module lamp_sequencer
  import lamp_seq_pkg::*;
#(
  parameter int unsigned CLKS_PER_STEP = 50_000_000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 switch_i,
  output logic [NUM_LAMPS-1:0] lamp_o,
  output logic [STATE_W-1:0]   state_o
);
  logic  tick;
  step_t state_d;
  step_t state_q;

  step_prescaler #(.CLKS_PER_STEP(CLKS_PER_STEP)) u_presc (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(switch_i), .tick_o(tick)
  );

  step_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(switch_i), .tick_i(tick),
    .state_d_o(state_d), .state_q_o(state_q)
  );

  lamp_register u_lamps (
    .clk_i(clk_i), .rst_ni(rst_ni), .state_d_i(state_d), .lamp_o(lamp_o)
  );

  assign state_o = state_q;

  assert_lamp_match_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lamp_o == lamp_mask(state_o));
  assert_dark_when_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !switch_i |=> (lamp_o == '0));
endmodule

// File: tb/lamp_sequencer_test.sv
module lamp_sequencer_test;
  localparam int CLK_PERIOD = 10;
  localparam int STEP = 4;

  typedef struct {
    logic [4:0] lamps;
    logic [1:0] state;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sw = 1'b0;
  logic [4:0] lamp_o;
  logic [1:0] state_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  exp_t q[$];
  event sample_ev;

  lamp_sequencer #(.CLKS_PER_STEP(STEP)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .switch_i(sw), .lamp_o(lamp_o), .state_o(state_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // R4 model: step code to lamp vector, bit 0 = lamp 1
  function automatic logic [4:0] model_lamps(input logic [1:0] s);
    case (s)
      2'd0: return 5'b00000;
      2'd1: return 5'b00011;
      2'd2: return 5'b01111;
      default: return 5'b11111;
    endcase
  endfunction

  task automatic push(input logic [1:0] s, input string tag);
    exp_t e;
    e.state = s; e.lamps = model_lamps(s); e.tag = tag;
    q.push_back(e);
    ->sample_ev;
    #1;
  endtask

  // monitor: pops and compares as results appear
  initial begin
    forever begin
      @(sample_ev);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (lamp_o !== e.lamps || state_o !== e.state) begin
          errors++;
          $display("FAIL %s: lamps=%b state=%b expected lamps=%b state=%b",
                   e.tag, lamp_o, state_o, e.lamps, e.state);
        end
      end
    end
  end

  // one full step from cur: still cur after STEP-1 edges, next after STEP
  task automatic run_step(input logic [1:0] cur, input string tag);
    repeat (STEP-1) @(posedge clk);
    @(negedge clk);
    push(cur, {tag, " R3 hold"});
    @(posedge clk);
    @(negedge clk);
    push(cur + 2'd1, {tag, " R2 R4 R5 advance"});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    push(2'd0, "R1 reset");
    rst_ni = 1'b1;
    @(negedge clk);
    push(2'd0, "R6 idle after reset");

    sw = 1'b1;
    begin
      logic [1:0] s = 2'd0;
      for (int i = 0; i < 10; i++) begin
        run_step(s, "R2 R3 R4 round");
        s = s + 2'd1;
      end
    end
    // state now 2 after 10 steps; drop switch mid-step
    repeat (2) @(posedge clk);
    @(negedge clk);
    sw = 1'b0;
    @(posedge clk);
    @(negedge clk);
    push(2'd0, "R6 switch off clears");
    repeat (STEP*3) @(posedge clk);
    @(negedge clk);
    push(2'd0, "R6 stays dark while off");

    // re-enable: dark step lasts a full second
    sw = 1'b1;
    run_step(2'd0, "R7 first step after enable");
    run_step(2'd1, "R7 second step");

    // brief off pulse one edge before tick: restart from zero
    repeat (STEP-1) @(posedge clk);
    @(negedge clk);
    sw = 1'b0;
    @(posedge clk);
    @(negedge clk);
    sw = 1'b1;
    push(2'd0, "R6 R8 short off");
    run_step(2'd0, "R7 after short off");

    // reset during run
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    push(2'd0, "R1 async reset");
    @(negedge clk);
    rst_ni = 1'b1;
    sw = 1'b0;
    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: expected completion, got timeout");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule